// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Array

The block holds two reloadable timers and an array of channel registers that share them. Each channel is tied to one of the two timers and works either as a timestamp latch or as a match detector. In capture mode, an edge on the channel's input pin stores the tied timer's current count and pulses the channel's interrupt line. In compare mode, the stored value is checked against the tied timer each time that timer advances. A match pulses the interrupt and can set, toggle or briefly assert the channel's output pin.

Each timer advances on a clock it picks from several sources: a power-of-four division of the system clock, a strobe from an outside timer, or (first timer only) rising edges on an external count input. A timer that passes its all-ones value reloads from its reload register and pulses its overflow output. Software reaches every register through a simple write strobe and a combinational read port.

Top module: `cc_timer_array`

## Requirements
- R1: After reset, all timers, reload registers, channel values, channel configurations and timer controls read 0. All pin outputs, interrupt lines and overflow outputs are low.
- R2: A timer control word has bit 3 = run and bits 2:0 = source. With run set, sources 0, 1, 2 and 3 advance the timer once every 1, 4, 16 and 64 clocks (4^source). With run clear, the timer holds its value.
- R3: Source 4 advances the timer in each cycle that extOvf is high. Source 5 advances timer 0 once per rising edge of extCount, which passes through a two-flop synchronizer. Timer 1 with source 5 does not advance.
- R4: A timer that advances from all ones loads its reload value on that same edge, and its tmrOvf bit is high for exactly the following cycle.
- R5: The register map is: channel values at addresses 0..NUM_CH-1; channel configurations at NUM_CH..2*NUM_CH-1; then, starting at 2*NUM_CH, timer 0 count, reload and control, followed by timer 1 count, reload and control. A bus write to a timer's count takes priority over an advance in the same cycle.
- R6: Channel configuration bit 4 ties the channel to timer 0 (value 0) or timer 1 (value 1). Only that timer's activity can capture into the channel or match against it.
- R7: Configuration bits 1:0 set the mode: 01 = capture, 10 = compare, 00 and 11 = off. In capture mode, bit 2 enables rising input edges and bit 3 enables falling input edges. The tied timer's value is stored on the third clock edge after the pin changes. An off channel neither stores anything nor raises an interrupt.
- R8: Each capture pulses that channel's irq for one cycle, on the same edge that stores the value.
- R9: A compare match is checked only in a cycle in which the tied timer advances (and is not being written). The check uses the value the timer takes on that edge. irq pulses on that edge. A timer that holds a value equal to the channel value raises no match.
- R10: Compare action bits 3:2 select what a match does: 00 pulses irq only, 01 sets the pin, 10 toggles the pin. Writing a channel's configuration clears its pin output.
- R11: Action 11 sets the pin on a match and clears it on the next overflow of the tied timer.
- R12: If a capture and a bus write reach the same channel value in the same cycle, the captured timer value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wrData | input | TW | Write data |
| rdData | output | TW | Combinational read data at addr |
| pinIn | input | NUM_CH | Channel capture inputs (asynchronous) |
| pinOut | output | NUM_CH | Channel compare outputs |
| irq | output | NUM_CH | Per-channel one-cycle interrupt pulses |
| extCount | input | 1 | External count input for timer 0 (asynchronous) |
| extOvf | input | 1 | Overflow strobe from an outside timer (synchronous) |
| tmrOvf | output | 2 | One-cycle overflow pulse per timer |

## Verification
The bench builds the block with NUM_CH = 4, TW = 8 and PRE_SHIFT = 2. With 8-bit timers, a wrap and reload is only a few counts away, so the overflow, toggle and set-then-clear cases run in a handful of cycles. The 4/16/64 dividers can each be measured exactly over a 64-cycle window. Four channels are enough to run a capture, a compare and an off channel side by side, and to put the two timebases against each other for the allocation check and the capture-versus-write collision.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_CAP  = 2'b01,
    MODE_CMP  = 2'b10,
    MODE_OFF2 = 2'b11
  } chanMode_e;

  typedef enum logic [1:0] {
    ACT_IRQ    = 2'b00,
    ACT_SET    = 2'b01,
    ACT_TOGGLE = 2'b10,
    ACT_PULSE  = 2'b11
  } cmpAct_e;

  // bit 4 timer select, bits 3:2 edge enables or compare action, bits 1:0 mode
  typedef struct packed {
    logic      tmrSel;
    logic [1:0] act;
    chanMode_e mode;
  } chanCfg_t;

  typedef struct packed {
    logic       run;
    logic [2:0] src;
  } tmrCtl_t;

  localparam logic [2:0] SRC_EXT_OVF = 3'd4;
  localparam logic [2:0] SRC_EXT_CNT = 3'd5;

  // strobes from control to datapath, one bit per timer
  typedef struct packed {
    logic [1:0] tick;
    logic [1:0] wrTmr;
    logic [1:0] wrRld;
  } tmrStrobe_t;

endpackage

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int TW        = 16,
  parameter int PRE_SHIFT = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [TW-1:0]              wrData,
  input  logic [NUM_CH-1:0]          pinIn,
  input  logic                       extCount,
  input  logic                       extOvf,
  input  logic [NUM_CH-1:0][TW-1:0]  chanVal,
  input  logic [1:0][TW-1:0]         tmrVal,
  input  logic [1:0][TW-1:0]         rldVal,
  output tmrStrobe_t                 strb,
  output logic [NUM_CH-1:0]          wrChan,
  output logic [NUM_CH-1:0]          cfgWr,
  output logic [NUM_CH-1:0]          capHit,
  output chanCfg_t [NUM_CH-1:0]      cfg,
  output logic [TW-1:0]              rdData
);

  localparam int PRE_W  = 3 * PRE_SHIFT;
  localparam int BASE_T = 2 * NUM_CH;

  logic [PRE_W-1:0]  preCnt;
  logic [3:0]        preTick;
  logic [NUM_CH-1:0] pinS1, pinS2, pinPrev, pinRise, pinFall;
  logic              extS1, extS2, extPrev, extRise;
  tmrCtl_t [1:0]     tctl;
  logic [1:0]        wrCtl;

  // free-running prescaler; division 4^s fires when the low s*PRE_SHIFT bits are all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign preTick[0] = 1'b1;
  for (genvar s = 1; s < 4; s++) begin : g_pre
    assign preTick[s] = &preCnt[s*PRE_SHIFT-1:0];
  end

  // input synchronizers and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS1   <= '0;
      pinS2   <= '0;
      pinPrev <= '0;
      extS1   <= 1'b0;
      extS2   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      pinS1   <= pinIn;
      pinS2   <= pinS1;
      pinPrev <= pinS2;
      extS1   <= extCount;
      extS2   <= extS1;
      extPrev <= extS2;
    end
  end

  assign pinRise = pinS2 & ~pinPrev;
  assign pinFall = ~pinS2 & pinPrev;
  assign extRise = extS2 & ~extPrev;

  // register write decode
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chDec
    assign wrChan[i] = wrEn && (addr == ADDR_W'(i));
    assign cfgWr[i]  = wrEn && (addr == ADDR_W'(NUM_CH + i));
    assign capHit[i] = (cfg[i].mode == MODE_CAP) &&
                       ((cfg[i].act[0] && pinRise[i]) || (cfg[i].act[1] && pinFall[i]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         cfg[i] <= '0;
      else if (cfgWr[i]) cfg[i] <= chanCfg_t'(wrData[4:0]);
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_tmr
    logic srcTick;

    assign strb.wrTmr[k] = wrEn && (addr == ADDR_W'(BASE_T + 3*k));
    assign strb.wrRld[k] = wrEn && (addr == ADDR_W'(BASE_T + 3*k + 1));
    assign wrCtl[k]      = wrEn && (addr == ADDR_W'(BASE_T + 3*k + 2));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         tctl[k] <= '0;
      else if (wrCtl[k]) tctl[k] <= tmrCtl_t'(wrData[3:0]);
    end

    if (k == 0) begin : g_extCnt
      always_comb begin
        if (tctl[k].src[2] == 1'b0)       srcTick = preTick[tctl[k].src[1:0]];
        else if (tctl[k].src == SRC_EXT_OVF) srcTick = extOvf;
        else if (tctl[k].src == SRC_EXT_CNT) srcTick = extRise;
        else                               srcTick = 1'b0;
      end
    end else begin : g_noExtCnt
      always_comb begin
        if (tctl[k].src[2] == 1'b0)       srcTick = preTick[tctl[k].src[1:0]];
        else if (tctl[k].src == SRC_EXT_OVF) srcTick = extOvf;
        else                               srcTick = 1'b0;
      end
    end

    assign strb.tick[k] = tctl[k].run && srcTick;
  end

  // combinational read port
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i))          rdData = chanVal[i];
      if (addr == ADDR_W'(NUM_CH + i)) rdData = TW'(cfg[i]);
    end
    for (int k = 0; k < 2; k++) begin
      if (addr == ADDR_W'(BASE_T + 3*k))     rdData = tmrVal[k];
      if (addr == ADDR_W'(BASE_T + 3*k + 1)) rdData = rldVal[k];
      if (addr == ADDR_W'(BASE_T + 3*k + 2)) rdData = TW'(tctl[k]);
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrChan, cfgWr, strb.wrTmr, strb.wrRld, wrCtl})); // R5

  AST_T1_NO_EXTCNT: assert property (@(posedge clk) disable iff (!rstN)
    (tctl[1].src == SRC_EXT_CNT) |-> !strb.tick[1]); // R3

endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TW     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tmrStrobe_t                 strb,
  input  logic [TW-1:0]              wrData,
  input  logic [NUM_CH-1:0]          wrChan,
  input  logic [NUM_CH-1:0]          cfgWr,
  input  logic [NUM_CH-1:0]          capHit,
  input  chanCfg_t [NUM_CH-1:0]      cfg,
  output logic [NUM_CH-1:0][TW-1:0]  chanVal,
  output logic [1:0][TW-1:0]         tmrVal,
  output logic [1:0][TW-1:0]         rldVal,
  output logic [NUM_CH-1:0]          pinOut,
  output logic [NUM_CH-1:0]          irq,
  output logic [1:0]                 tmrOvf
);

  localparam logic [TW-1:0] TMAX = '1;

  logic [1:0][TW-1:0] tmrNext;
  logic [1:0]         wrapNow;

  for (genvar k = 0; k < 2; k++) begin : g_tmr
    assign tmrNext[k] = (tmrVal[k] == TMAX) ? rldVal[k] : tmrVal[k] + 1'b1;
    assign wrapNow[k] = strb.tick[k] && !strb.wrTmr[k] && (tmrVal[k] == TMAX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmrVal[k] <= '0;
        rldVal[k] <= '0;
        tmrOvf[k] <= 1'b0;
      end else begin
        if (strb.wrRld[k]) rldVal[k] <= wrData;
        if (strb.wrTmr[k])     tmrVal[k] <= wrData;
        else if (strb.tick[k]) tmrVal[k] <= tmrNext[k];
        tmrOvf[k] <= wrapNow[k];
      end
    end

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.tick[k] && !strb.wrTmr[k]) |=> $stable(tmrVal[k])); // R2

    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
      tmrOvf[k] |-> (tmrVal[k] == $past(rldVal[k]))); // R4
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic          sel;
    logic [TW-1:0] tNow;
    logic          matchNow;

    assign sel      = cfg[i].tmrSel;
    assign tNow     = tmrVal[sel];
    assign matchNow = (cfg[i].mode == MODE_CMP) && strb.tick[sel] && !strb.wrTmr[sel] &&
                      (chanVal[i] == tmrNext[sel]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanVal[i] <= '0;
        irq[i]     <= 1'b0;
        pinOut[i]  <= 1'b0;
      end else begin
        if (capHit[i])      chanVal[i] <= tNow;
        else if (wrChan[i]) chanVal[i] <= wrData;
        irq[i] <= capHit[i] || matchNow;
        if (cfgWr[i]) begin
          pinOut[i] <= 1'b0;
        end else if (cfg[i].mode == MODE_CMP) begin
          unique case (cmpAct_e'(cfg[i].act))
            ACT_IRQ:    ;
            ACT_SET:    if (matchNow) pinOut[i] <= 1'b1;
            ACT_TOGGLE: if (matchNow) pinOut[i] <= ~pinOut[i];
            ACT_PULSE: begin
              if (matchNow)          pinOut[i] <= 1'b1;
              else if (wrapNow[sel]) pinOut[i] <= 1'b0;
            end
          endcase
        end
      end
    end

    AST_CMP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
      (irq[i] && $past(cfg[i].mode == MODE_CMP)) |-> $past(strb.tick[cfg[i].tmrSel])); // R9

    AST_CAP_WINS: assert property (@(posedge clk) disable iff (!rstN)
      $past(capHit[i] && wrChan[i]) |-> (chanVal[i] == $past(tNow))); // R12

    AST_CAP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      capHit[i] |=> irq[i]); // R8
  end

endmodule

// File: rtl/cc_timer_array.sv
module cc_timer_array
  import cc_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int TW        = 16,
  parameter int PRE_SHIFT = 2,
  parameter int ADDR_W    = $clog2(2*NUM_CH + 6)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TW-1:0]     wrData,
  output logic [TW-1:0]     rdData,
  input  logic [NUM_CH-1:0] pinIn,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] irq,
  input  logic              extCount,
  input  logic              extOvf,
  output logic [1:0]        tmrOvf
);

  tmrStrobe_t                strb;
  logic [NUM_CH-1:0]         wrChan, cfgWr, capHit;
  chanCfg_t [NUM_CH-1:0]     cfg;
  logic [NUM_CH-1:0][TW-1:0] chanVal;
  logic [1:0][TW-1:0]        tmrVal, rldVal;

  cc_ctrl #(
    .NUM_CH(NUM_CH), .TW(TW), .PRE_SHIFT(PRE_SHIFT), .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .pinIn(pinIn), .extCount(extCount), .extOvf(extOvf),
    .chanVal(chanVal), .tmrVal(tmrVal), .rldVal(rldVal),
    .strb(strb), .wrChan(wrChan), .cfgWr(cfgWr), .capHit(capHit),
    .cfg(cfg), .rdData(rdData)
  );

  cc_datapath #(
    .NUM_CH(NUM_CH), .TW(TW)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .wrChan(wrChan), .cfgWr(cfgWr), .capHit(capHit), .cfg(cfg),
    .chanVal(chanVal), .tmrVal(tmrVal), .rldVal(rldVal),
    .pinOut(pinOut), .irq(irq), .tmrOvf(tmrOvf)
  );

endmodule

// File: tb/test_cc_timer_array.sv
module test_cc_timer_array;

  localparam int NCH = 4;
  localparam int TWB = 8;
  localparam int AW  = 4;
  // register map for NCH = 4
  localparam int A_CFG = 4;
  localparam int A_T0  = 8, A_R0 = 9,  A_C0 = 10;
  localparam int A_T1  = 11, A_R1 = 12, A_C1 = 13;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [TWB-1:0] wrData = '0;
  logic [TWB-1:0] rdData;
  logic [NCH-1:0] pinIn = '0;
  logic [NCH-1:0] pinOut, irq;
  logic           extCount = 1'b0;
  logic           extOvf = 1'b0;
  logic [1:0]     tmrOvf;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cc_timer_array #(.NUM_CH(NCH), .TW(TWB), .PRE_SHIFT(2), .ADDR_W(AW)) i_cc_timer_array (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .pinIn(pinIn), .pinOut(pinOut), .irq(irq), .extCount(extCount), .extOvf(extOvf),
    .tmrOvf(tmrOvf)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wrData = TWB'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output int v);
    addr = AW'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic expectReg(input string req, input int a, input int exp);
    int v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    for (int a = 0; a < 14; a++) expectReg("R1 register", a, 0);
    check("R1 pinOut", int'(pinOut), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 tmrOvf", int'(tmrOvf), 0);
  endtask

  task automatic testPrescale();
    busWrite(A_T0, 10);
    busWrite(A_C0, 8);
    cyc(5);
    expectReg("R2 div1", A_T0, 15);
    for (int s = 1; s < 4; s++) begin
      busWrite(A_C0, 0);
      busWrite(A_T0, 0);
      busWrite(A_C0, 8 | s);
      cyc(64);
      expectReg("R2 div4^s", A_T0, 64 >> (2*s));
    end
    busWrite(A_C0, 0);
    busWrite(A_T0, 5);
    cyc(10);
    expectReg("R2 run clear holds", A_T0, 5);
  endtask

  task automatic testExtSources();
    busWrite(A_T0, 0);
    busWrite(A_C0, 8 | 4);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); extOvf = 1'b1;
      @(negedge clk); extOvf = 1'b0;
      cyc(2);
    end
    expectReg("R3 ext overflow source", A_T0, 3);
    busWrite(A_C0, 0);
    busWrite(A_T0, 0);
    busWrite(A_C0, 8 | 5);
    busWrite(A_T1, 0);
    busWrite(A_C1, 8 | 5);
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); extCount = 1'b1;
      cyc(4);
      extCount = 1'b0;
      cyc(4);
    end
    expectReg("R3 ext count on T0", A_T0, 2);
    expectReg("R3 T1 ignores ext count", A_T1, 0);
    busWrite(A_C0, 0);
    busWrite(A_C1, 0);
  endtask

  task automatic testOverflow();
    busWrite(A_R1, 'h40);
    busWrite(A_T1, 'hFD);
    busWrite(A_C1, 8);
    cyc(1); expectReg("R4 step FE", A_T1, 'hFE); check("R4 no ovf", int'(tmrOvf), 0);
    cyc(1); expectReg("R4 step FF", A_T1, 'hFF);
    cyc(1); expectReg("R4 reload", A_T1, 'h40); check("R4 ovf pulse", int'(tmrOvf), 2);
    cyc(1); expectReg("R4 after reload", A_T1, 'h41); check("R4 ovf one cycle", int'(tmrOvf), 0);
    busWrite(A_C1, 0);
  endtask

  task automatic testWritePriority();
    busWrite(A_C0, 8);
    busWrite(A_T0, 'h20);
    expectReg("R5 write beats tick", A_T0, 'h20);
    busWrite(A_C0, 0);
    busWrite(A_R0, 'h5A);
    expectReg("R5 reload readback", A_R0, 'h5A);
    expectReg("R5 control readback", A_C0, 0);
  endtask

  task automatic testCompareSet();
    busWrite(A_T0, 'h30);
    busWrite(1, 'h33);
    busWrite(A_CFG + 1, 'h06);   // compare, set action, timer 0
    expectReg("R10 config readback", A_CFG + 1, 'h06);
    busWrite(A_C0, 8);
    cyc(1); check("R9 no early match", int'(irq[1]), 0);
    cyc(1); check("R10 pin still low", int'(pinOut[1]), 0);
    cyc(1); check("R9 irq on match", int'(irq[1]), 1); check("R10 set pin", int'(pinOut[1]), 1);
    cyc(1); check("R9 irq one cycle", int'(irq[1]), 0); check("R10 pin stays", int'(pinOut[1]), 1);
    busWrite(A_C0, 0);
    busWrite(A_CFG + 1, 'h06);
    check("R10 config write clears pin", int'(pinOut[1]), 0);
  endtask

  task automatic testCompareNoTick();
    int seen = 0;
    busWrite(A_T0, 'h50);
    busWrite(2, 'h50);
    busWrite(A_CFG + 2, 'h02);   // compare, irq only, timer 0
    for (int c = 0; c < 6; c++) begin cyc(1); seen += int'(irq[2]); end
    check("R9 held equal value no match", seen, 0);
    busWrite(A_T0, 'h4F);
    busWrite(A_C0, 8);
    cyc(1); check("R9 match on advance", int'(irq[2]), 1);
    busWrite(A_C0, 0);
    busWrite(A_CFG + 2, 0);
  endtask

  task automatic testToggle();
    busWrite(A_R1, 'hFE);
    busWrite(A_T1, 'hFE);
    busWrite(2, 'hFF);
    busWrite(A_CFG + 2, 'h1A);   // compare, toggle, timer 1
    busWrite(A_C1, 8);
    cyc(1); check("R10 toggle high", int'(pinOut[2]), 1);
    cyc(1); check("R10 toggle holds", int'(pinOut[2]), 1);
    cyc(1); check("R10 toggle low", int'(pinOut[2]), 0);
    cyc(2); check("R10 toggle high again", int'(pinOut[2]), 1);
    busWrite(A_C1, 0);
    busWrite(A_CFG + 2, 0);
  endtask

  task automatic testSetClear();
    int seen0 = 0;
    busWrite(A_T0, 0);
    busWrite(0, 'hFD);
    busWrite(A_CFG + 0, 'h02);   // compare on timer 0, which stays still
    busWrite(A_R1, 'h80);
    busWrite(A_T1, 'hFC);
    busWrite(3, 'hFD);
    busWrite(A_CFG + 3, 'h1E);   // compare, set then clear, timer 1
    busWrite(A_C1, 8);
    cyc(1); seen0 += int'(irq[0]); check("R11 set on match", int'(pinOut[3]), 1);
    cyc(1); seen0 += int'(irq[0]);
    cyc(1); seen0 += int'(irq[0]); check("R11 held until overflow", int'(pinOut[3]), 1);
    cyc(1); seen0 += int'(irq[0]); check("R11 cleared on overflow", int'(pinOut[3]), 0);
    check("R6 timer0 channel ignores timer1", seen0, 0);
    busWrite(A_C1, 0);
    busWrite(A_CFG + 0, 0);
    busWrite(A_CFG + 3, 0);
  endtask

  task automatic testCapture();
    int seen = 0;
    busWrite(A_T1, 'h55);
    busWrite(A_CFG + 0, 'h15);   // capture rising, timer 1
    @(negedge clk); pinIn[0] = 1'b1;
    cyc(1); check("R7 latency edge 1", int'(irq[0]), 0);
    cyc(1); check("R7 latency edge 2", int'(irq[0]), 0);
    cyc(1); check("R8 capture irq", int'(irq[0]), 1); expectReg("R7 captured value", 0, 'h55);
    cyc(1); check("R8 irq one cycle", int'(irq[0]), 0);
    busWrite(A_T1, 'h66);
    pinIn[0] = 1'b0;
    for (int c = 0; c < 5; c++) begin cyc(1); seen += int'(irq[0]); end
    check("R7 rising-only ignores fall", seen, 0);
    expectReg("R7 value kept on fall", 0, 'h55);
    busWrite(A_CFG + 0, 'h19);   // capture falling, timer 1
    seen = 0;
    pinIn[0] = 1'b1;
    for (int c = 0; c < 5; c++) begin cyc(1); seen += int'(irq[0]); end
    check("R7 falling-only ignores rise", seen, 0);
    pinIn[0] = 1'b0;
    for (int c = 0; c < 5; c++) begin cyc(1); seen += int'(irq[0]); end
    check("R8 falling capture irq count", seen, 1);
    expectReg("R7 falling capture", 0, 'h66);
    busWrite(A_CFG + 0, 'h1D);   // both edges
    busWrite(A_T1, 'h77);
    pinIn[0] = 1'b1; cyc(5);
    expectReg("R7 both, rise", 0, 'h77);
    busWrite(A_T1, 'h78);
    pinIn[0] = 1'b0; cyc(5);
    expectReg("R7 both, fall", 0, 'h78);
    busWrite(A_CFG + 0, 0);
  endtask

  task automatic testOffChannel();
    int seen = 0;
    busWrite(A_CFG + 2, 0);
    busWrite(2, 'h12);
    for (int p = 0; p < 2; p++) begin
      pinIn[2] = ~pinIn[2];
      for (int c = 0; c < 5; c++) begin cyc(1); seen += int'(irq[2]); end
    end
    check("R7 off channel no irq", seen, 0);
    expectReg("R7 off channel value kept", 2, 'h12);
  endtask

  task automatic testCollision();
    busWrite(A_C0, 0);
    busWrite(A_T0, 'h77);
    busWrite(A_CFG + 1, 'h05);   // capture rising, timer 0
    @(negedge clk); pinIn[1] = 1'b1;
    cyc(2);
    addr = AW'(1); wrData = 'h11; wrEn = 1'b1;   // lands on the capture edge
    @(negedge clk); wrEn = 1'b0;
    check("R12 capture irq", int'(irq[1]), 1);
    expectReg("R12 capture beats write", 1, 'h77);
    busWrite(A_CFG + 1, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    testReset();
    testPrescale();
    testExtSources();
    testOverflow();
    testWritePriority();
    testCompareSet();
    testCompareNoTick();
    testToggle();
    testSetClear();
    testCapture();
    testOffChannel();
    testCollision();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule